// File: doc/BRIEF.md
# AXI Master-Port Slave Selector

This block sits on one master port of a four-by-four AXI interconnect. It accepts the five AXI channels of a single master and steers every command to one of four slave-side ports. The target is picked from the two most significant address bits. The lower address bits go to the slave unchanged. Toward the slave, each command ID is widened by a two-bit tag that identifies this master port. On returning responses that tag is removed, so the master sees its own 7-bit IDs again.

Switching between slaves is non-posted. While any write or read is outstanding at the current slave, a command for a different slave is held off. It is released only after every write response and every final read beat from the current slave has come back. Write commands are paced by their data. After a write command is accepted, the write-address ready stays low until the final beat of that command's data has been taken. Data is taken only after its command has been accepted.

The routing paths are combinational from master to slave. All decisions rest on three registered items: the current slave, the outstanding write and read counts, and a flag that marks write data as owed.

Top module: `axi_mport_router`

## Requirements
- R1: The slave index is awaddr/araddr bits [ADDR_W-1:ADDR_W-2], with 00 selecting slave 0, 01 slave 1, 10 slave 2 and 11 slave 3. Only that slave's bit of s_awvalid/s_arvalid may be high, and any slave may be reached.
- R2: The slave-side address s_awaddr/s_araddr is the master address with its two top bits removed, i.e. bits [ADDR_W-3:0].
- R3: While any write or read is outstanding, a command for a slave other than the current one raises no slave-side valid and gets no ready. It proceeds once all outstanding responses have returned.
- R4: The slave-side ID s_awid/s_arid is {MASTER_IDX[1:0], awid/arid}, with a 7-bit user ID forming a 9-bit slave ID.
- R5: bid/rid equal bits [6:0] of the 9-bit ID returned by the current slave; the tag bits [8:7] are dropped.
- R6: In the cycle after an awvalid&awready handshake, awready is low. It stays low until the handshake of the wvalid&wready beat with wlast=1. wready is low while no accepted command is owed data.
- R7: Write data goes only to the slave of the command it belongs to (one-hot s_wvalid on that slave).
- R8: Only the current slave's response channels reach the master. The other slaves' s_bready/s_rready stay low, and their s_bvalid/s_rvalid are not seen on bvalid/rvalid.
- R9: A read stays outstanding until the beat with rlast=1 is handshaken. A non-final beat does not release a switch to another slave.
- R10: When idle, if a write and a read for different slaves arrive in the same cycle, the write is forwarded first and the read is held.
- R11: After reset, nothing is outstanding. bvalid and rvalid are low, and a command to any slave is forwarded at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| awvalid | input | 1 | Master write command valid |
| awready | output | 1 | Master write command ready |
| awaddr | input | ADDR_W | Master write address |
| awid | input | UID_W | Master write ID |
| wvalid | input | 1 | Master write data valid |
| wready | output | 1 | Master write data ready |
| wdata | input | DATA_W | Master write data |
| wlast | input | 1 | Final write beat |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| bid | output | UID_W | Write response ID, tag removed |
| bresp | output | 2 | Write response code |
| arvalid | input | 1 | Master read command valid |
| arready | output | 1 | Master read command ready |
| araddr | input | ADDR_W | Master read address |
| arid | input | UID_W | Master read ID |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| rid | output | UID_W | Read ID, tag removed |
| rdata | output | DATA_W | Read data |
| rresp | output | 2 | Read response code |
| rlast | output | 1 | Final read beat |
| s_awvalid | output | 4 | Per-slave write command valid |
| s_awready | input | 4 | Per-slave write command ready |
| s_awaddr | output | ADDR_W-2 | Slave write address |
| s_awid | output | UID_W+2 | Tagged write ID |
| s_wvalid | output | 4 | Per-slave write data valid |
| s_wready | input | 4 | Per-slave write data ready |
| s_wdata | output | DATA_W | Slave write data |
| s_wlast | output | 1 | Slave final write beat |
| s_bvalid | input | 4 | Per-slave write response valid |
| s_bready | output | 4 | Per-slave write response ready |
| s_bid | input | 4*(UID_W+2) | Per-slave tagged response IDs, slave i at slice i |
| s_bresp | input | 8 | Per-slave response codes |
| s_arvalid | output | 4 | Per-slave read command valid |
| s_arready | input | 4 | Per-slave read command ready |
| s_araddr | output | ADDR_W-2 | Slave read address |
| s_arid | output | UID_W+2 | Tagged read ID |
| s_rvalid | input | 4 | Per-slave read data valid |
| s_rready | output | 4 | Per-slave read data ready |
| s_rid | input | 4*(UID_W+2) | Per-slave tagged read IDs |
| s_rdata | input | 4*DATA_W | Per-slave read data |
| s_rresp | input | 8 | Per-slave read response codes |
| s_rlast | input | 4 | Per-slave final read beat |

## Verification
On every cycle, the embedded properties check four things: slave-side valids are at most one-hot, the current slave holds while work is outstanding, an off-target command reaches no slave unless the port is idle, and the ID tag is correct in both directions. They also check the awready gap after each write command and that the data-owed flag rises only after a command handshake. Other behaviours appear only in the bench's scenarios. These are the actual release of a held command once the last response drains, the refusal to release on a non-final read beat, the write-first rule when both channels arrive idle, and the suppression of stray responses from non-current slaves.

// File: rtl/axi_sel_pkg.sv
package axi_sel_pkg;
  localparam int NUM_SLV = 4;
  localparam int SEL_W   = 2;

  function automatic logic [NUM_SLV-1:0] sel_onehot(input logic [SEL_W-1:0] s);
    logic [NUM_SLV-1:0] v;
    v = '0;
    v[s] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/asel_decode.sv
module asel_decode
  import axi_sel_pkg::*;
#(
  parameter int ADDR_W = 31
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [SEL_W-1:0]    sel,
  output logic [ADDR_W-3:0]   lo_addr
);
  assign sel     = addr[ADDR_W-1 -: SEL_W];
  assign lo_addr = addr[ADDR_W-3:0];
endmodule

// File: rtl/asel_tracker.sv
module asel_tracker
  import axi_sel_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             aw_fire,
  input  logic             ar_fire,
  input  logic             b_fire,
  input  logic             rlast_fire,
  input  logic [SEL_W-1:0] aw_sel,
  input  logic [SEL_W-1:0] ar_sel,
  output logic [SEL_W-1:0] cur_slv,
  output logic             wr_busy,
  output logic             rd_busy,
  output logic             wr_full,
  output logic             rd_full
);
  logic [CNT_W-1:0] wr_cnt, rd_cnt;
  logic             idle;

  assign idle    = (wr_cnt == '0) && (rd_cnt == '0);
  assign wr_busy = (wr_cnt != '0);
  assign rd_busy = (rd_cnt != '0);
  assign wr_full = (wr_cnt == '1);
  assign rd_full = (rd_cnt == '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_cnt  <= '0;
      rd_cnt  <= '0;
      cur_slv <= '0;
    end else begin
      case ({aw_fire, b_fire})
        2'b10:   wr_cnt <= wr_cnt + 1'b1;
        2'b01:   wr_cnt <= wr_cnt - 1'b1;
        default: wr_cnt <= wr_cnt;
      endcase
      case ({ar_fire, rlast_fire})
        2'b10:   rd_cnt <= rd_cnt + 1'b1;
        2'b01:   rd_cnt <= rd_cnt - 1'b1;
        default: rd_cnt <= rd_cnt;
      endcase
      if (idle) begin
        if (aw_fire)      cur_slv <= aw_sel;
        else if (ar_fire) cur_slv <= ar_sel;
      end
    end
  end

  // R3: the target cannot move while anything is outstanding
  assert_cur_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_busy || rd_busy) |=> $stable(cur_slv));

  // R9: a non-final read beat never empties the read count on its own
  assert_rd_drain_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_busy && !rlast_fire) |=> rd_busy);
endmodule

// File: rtl/asel_wgate.sv
module asel_wgate (
  input  logic clk,
  input  logic rst,
  input  logic aw_fire,
  input  logic wlast_fire,
  output logic w_pend
);
  always_ff @(posedge clk) begin
    if (rst)             w_pend <= 1'b0;
    else if (aw_fire)    w_pend <= 1'b1;
    else if (wlast_fire) w_pend <= 1'b0;
  end

  // R6: data becomes owed only through a command handshake
  assert_owed_after_cmd_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(w_pend) |-> $past(aw_fire));
endmodule

// File: rtl/asel_resp.sv
module asel_resp
  import axi_sel_pkg::*;
#(
  parameter int UID_W  = 7,
  parameter int DATA_W = 64,
  parameter int MASTER_IDX = 0
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [SEL_W-1:0]              cur_slv,
  input  logic                          wr_busy,
  input  logic                          rd_busy,
  input  logic [NUM_SLV-1:0]            s_bvalid,
  output logic [NUM_SLV-1:0]            s_bready,
  input  logic [NUM_SLV*(UID_W+2)-1:0]  s_bid,
  input  logic [NUM_SLV*2-1:0]          s_bresp,
  input  logic [NUM_SLV-1:0]            s_rvalid,
  output logic [NUM_SLV-1:0]            s_rready,
  input  logic [NUM_SLV*(UID_W+2)-1:0]  s_rid,
  input  logic [NUM_SLV*DATA_W-1:0]     s_rdata,
  input  logic [NUM_SLV*2-1:0]          s_rresp,
  input  logic [NUM_SLV-1:0]            s_rlast,
  output logic                          bvalid,
  input  logic                          bready,
  output logic [UID_W-1:0]              bid,
  output logic [1:0]                    bresp,
  output logic                          rvalid,
  input  logic                          rready,
  output logic [UID_W-1:0]              rid,
  output logic [DATA_W-1:0]             rdata,
  output logic [1:0]                    rresp,
  output logic                          rlast
);
  localparam int DID_W = UID_W + 2;
  localparam logic [1:0] MIDX = 2'(MASTER_IDX);

  logic [DID_W-1:0] b_full_id, r_full_id;

  assign b_full_id = s_bid[cur_slv*DID_W +: DID_W];
  assign r_full_id = s_rid[cur_slv*DID_W +: DID_W];

  assign bvalid = s_bvalid[cur_slv] && wr_busy;
  assign bid    = b_full_id[UID_W-1:0];
  assign bresp  = s_bresp[cur_slv*2 +: 2];

  assign rvalid = s_rvalid[cur_slv] && rd_busy;
  assign rid    = r_full_id[UID_W-1:0];
  assign rdata  = s_rdata[cur_slv*DATA_W +: DATA_W];
  assign rresp  = s_rresp[cur_slv*2 +: 2];
  assign rlast  = s_rlast[cur_slv];

  for (genvar i = 0; i < NUM_SLV; i++) begin : g_rsp
    assign s_bready[i] = bready && wr_busy && (cur_slv == SEL_W'(i));
    assign s_rready[i] = rready && rd_busy && (cur_slv == SEL_W'(i));
  end

  // R5: responses reaching the master carry this port's tag at the slave side
  assert_resp_tag_R5: assert property (@(posedge clk) disable iff (rst)
    (bvalid && bready) |-> (b_full_id[DID_W-1 -: 2] == MIDX));
  assert_rresp_tag_R5: assert property (@(posedge clk) disable iff (rst)
    (rvalid && rready) |-> (r_full_id[DID_W-1 -: 2] == MIDX));
  // R8: at most one slave is offered a ready
  assert_one_bready_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(s_bready) && $onehot0(s_rready));
endmodule

// File: rtl/axi_mport_router.sv
module axi_mport_router
  import axi_sel_pkg::*;
#(
  parameter int ADDR_W     = 31,
  parameter int UID_W      = 7,
  parameter int DATA_W     = 64,
  parameter int CNT_W      = 4,
  parameter int MASTER_IDX = 0
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          awvalid,
  output logic                          awready,
  input  logic [ADDR_W-1:0]             awaddr,
  input  logic [UID_W-1:0]              awid,
  input  logic                          wvalid,
  output logic                          wready,
  input  logic [DATA_W-1:0]             wdata,
  input  logic                          wlast,
  output logic                          bvalid,
  input  logic                          bready,
  output logic [UID_W-1:0]              bid,
  output logic [1:0]                    bresp,
  input  logic                          arvalid,
  output logic                          arready,
  input  logic [ADDR_W-1:0]             araddr,
  input  logic [UID_W-1:0]              arid,
  output logic                          rvalid,
  input  logic                          rready,
  output logic [UID_W-1:0]              rid,
  output logic [DATA_W-1:0]             rdata,
  output logic [1:0]                    rresp,
  output logic                          rlast,
  output logic [3:0]                    s_awvalid,
  input  logic [3:0]                    s_awready,
  output logic [ADDR_W-3:0]             s_awaddr,
  output logic [UID_W+1:0]              s_awid,
  output logic [3:0]                    s_wvalid,
  input  logic [3:0]                    s_wready,
  output logic [DATA_W-1:0]             s_wdata,
  output logic                          s_wlast,
  input  logic [3:0]                    s_bvalid,
  output logic [3:0]                    s_bready,
  input  logic [4*(UID_W+2)-1:0]        s_bid,
  input  logic [7:0]                    s_bresp,
  output logic [3:0]                    s_arvalid,
  input  logic [3:0]                    s_arready,
  output logic [ADDR_W-3:0]             s_araddr,
  output logic [UID_W+1:0]              s_arid,
  input  logic [3:0]                    s_rvalid,
  output logic [3:0]                    s_rready,
  input  logic [4*(UID_W+2)-1:0]        s_rid,
  input  logic [4*DATA_W-1:0]           s_rdata,
  input  logic [7:0]                    s_rresp,
  input  logic [3:0]                    s_rlast
);
  localparam int DID_W = UID_W + 2;
  localparam logic [1:0] MIDX = 2'(MASTER_IDX);

  logic [SEL_W-1:0] aw_sel, ar_sel, cur_slv;
  logic wr_busy, rd_busy, wr_full, rd_full, idle, w_pend;
  logic aw_ok, ar_ok, aw_req;
  logic aw_fire, ar_fire, wlast_fire, b_fire, rlast_fire;

  asel_decode #(.ADDR_W(ADDR_W)) u_aw_dec (.addr(awaddr), .sel(aw_sel), .lo_addr(s_awaddr));
  asel_decode #(.ADDR_W(ADDR_W)) u_ar_dec (.addr(araddr), .sel(ar_sel), .lo_addr(s_araddr));

  assign idle   = !wr_busy && !rd_busy;
  assign aw_ok  = (idle || (aw_sel == cur_slv)) && !w_pend && !wr_full;
  assign aw_req = awvalid && aw_ok;
  // a read may switch slaves only if no write is heading elsewhere this cycle
  assign ar_ok  = !rd_full && (idle ? (!aw_req || (aw_sel == ar_sel))
                                    : (ar_sel == cur_slv));

  assign awready = aw_ok && s_awready[aw_sel];
  assign arready = ar_ok && s_arready[ar_sel];
  assign wready  = w_pend && s_wready[cur_slv];

  assign s_awid  = {MIDX, awid};
  assign s_arid  = {MIDX, arid};
  assign s_wdata = wdata;
  assign s_wlast = wlast;

  for (genvar i = 0; i < NUM_SLV; i++) begin : g_req
    assign s_awvalid[i] = aw_req && (aw_sel == SEL_W'(i));
    assign s_arvalid[i] = arvalid && ar_ok && (ar_sel == SEL_W'(i));
    assign s_wvalid[i]  = wvalid && w_pend && (cur_slv == SEL_W'(i));
  end

  assign aw_fire    = awvalid && awready;
  assign ar_fire    = arvalid && arready;
  assign wlast_fire = wvalid && wready && wlast;
  assign b_fire     = bvalid && bready;
  assign rlast_fire = rvalid && rready && rlast;

  asel_tracker #(.CNT_W(CNT_W)) u_track (
    .clk(clk), .rst(rst),
    .aw_fire(aw_fire), .ar_fire(ar_fire), .b_fire(b_fire), .rlast_fire(rlast_fire),
    .aw_sel(aw_sel), .ar_sel(ar_sel), .cur_slv(cur_slv),
    .wr_busy(wr_busy), .rd_busy(rd_busy), .wr_full(wr_full), .rd_full(rd_full)
  );

  asel_wgate u_wgate (
    .clk(clk), .rst(rst), .aw_fire(aw_fire), .wlast_fire(wlast_fire), .w_pend(w_pend)
  );

  asel_resp #(.UID_W(UID_W), .DATA_W(DATA_W), .MASTER_IDX(MASTER_IDX)) u_resp (
    .clk(clk), .rst(rst), .cur_slv(cur_slv), .wr_busy(wr_busy), .rd_busy(rd_busy),
    .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bid(s_bid), .s_bresp(s_bresp),
    .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rid(s_rid), .s_rdata(s_rdata),
    .s_rresp(s_rresp), .s_rlast(s_rlast),
    .bvalid(bvalid), .bready(bready), .bid(bid), .bresp(bresp),
    .rvalid(rvalid), .rready(rready), .rid(rid), .rdata(rdata),
    .rresp(rresp), .rlast(rlast)
  );

  // R1: at most one slave sees a command on each address channel
  assert_onehot_cmd_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(s_awvalid) && $onehot0(s_arvalid) && $onehot0(s_wvalid));
  // R3: a command toward a non-current slave leaves only from an idle port
  assert_switch_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (((s_awvalid | s_arvalid) & ~sel_onehot(cur_slv)) != '0) |-> idle);
  // R4: commands toward slaves carry this port's tag
  assert_id_tag_R4: assert property (@(posedge clk) disable iff (rst)
    (s_awvalid != '0) |-> (s_awid[DID_W-1 -: 2] == MIDX));
  // R6: write command ready drops right after each accepted command
  assert_aw_gap_R6: assert property (@(posedge clk) disable iff (rst)
    aw_fire |=> !awready);
endmodule

// File: tb/axi_mport_router_bench.sv
module axi_mport_router_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 31, UW = 7, DW = 64, DIW = 9, MI = 2;
  localparam logic [1:0] MIDX = 2'(MI);

  logic clk = 0, rst = 1;
  logic awvalid = 0, wvalid = 0, wlast = 0, bready = 1, arvalid = 0, rready = 1;
  logic [AW-1:0] awaddr = '0, araddr = '0;
  logic [UW-1:0] awid = '0, arid = '0;
  logic [DW-1:0] wdata = '0;
  logic awready, wready, bvalid, arready, rvalid, rlast;
  logic [UW-1:0] bid, rid;
  logic [1:0] bresp, rresp;
  logic [DW-1:0] rdata;
  logic [3:0] s_awvalid, s_wvalid, s_bready, s_arvalid, s_rready;
  logic [3:0] s_awready = 4'hF, s_wready = 4'hF, s_arready = 4'hF;
  logic [3:0] s_bvalid = 0, s_rvalid = 0, s_rlast = 0;
  logic [AW-3:0] s_awaddr, s_araddr;
  logic [DIW-1:0] s_awid, s_arid;
  logic s_wlast;
  logic [DW-1:0] s_wdata;
  logic [4*DIW-1:0] s_bid = '0, s_rid = '0;
  logic [4*DW-1:0] s_rdata = '0;
  logic [7:0] s_bresp = '0, s_rresp = '0;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  axi_mport_router #(.ADDR_W(AW), .UID_W(UW), .DATA_W(DW), .MASTER_IDX(MI)) u_axi_mport_router (
    .clk(clk), .rst(rst),
    .awvalid(awvalid), .awready(awready), .awaddr(awaddr), .awid(awid),
    .wvalid(wvalid), .wready(wready), .wdata(wdata), .wlast(wlast),
    .bvalid(bvalid), .bready(bready), .bid(bid), .bresp(bresp),
    .arvalid(arvalid), .arready(arready), .araddr(araddr), .arid(arid),
    .rvalid(rvalid), .rready(rready), .rid(rid), .rdata(rdata), .rresp(rresp), .rlast(rlast),
    .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr), .s_awid(s_awid),
    .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wlast(s_wlast),
    .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bid(s_bid), .s_bresp(s_bresp),
    .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr), .s_arid(s_arid),
    .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rid(s_rid), .s_rdata(s_rdata),
    .s_rresp(s_rresp), .s_rlast(s_rlast)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk_addr(input logic [1:0] s, input logic [AW-3:0] lo);
    return {s, lo};
  endfunction

  task automatic step(); @(posedge clk); @(negedge clk); endtask

  task automatic do_write(input logic [1:0] s, input logic [UW-1:0] id);
    awvalid = 1; awaddr = mk_addr(s, AW'(29'h0ABC_0000 + id)); awid = id; #1;
    chk("R1 aw route", 64'(s_awvalid), 64'(4'b1 << s));
    chk("R2 aw addr", 64'(s_awaddr), 64'(awaddr[AW-3:0]));
    chk("R4 aw id", 64'(s_awid), 64'({MIDX, id}));
    step(); awvalid = 0; #1;
    chk("R6 aw gap", 64'(awready), 64'(0));
    wvalid = 1; wlast = 1; wdata = 64'hD00D + id; #1;
    chk("R7 w route", 64'(s_wvalid), 64'(4'b1 << s));
    step(); wvalid = 0; wlast = 0; #1;
    chk("R6 aw back", 64'(awready), 64'(1));
    s_bvalid[s] = 1; s_bid[s*DIW +: DIW] = {MIDX, id}; #1;
    chk("R5 bid strip", 64'({bvalid, bid}), 64'({1'b1, id}));
    step(); s_bvalid = 0;
  endtask

  task automatic do_read(input logic [1:0] s, input logic [UW-1:0] id);
    arvalid = 1; araddr = mk_addr(s, AW'(29'h0123_4560 + id)); arid = id; #1;
    chk("R1 ar route", 64'(s_arvalid), 64'(4'b1 << s));
    chk("R2 ar addr", 64'(s_araddr), 64'(araddr[AW-3:0]));
    chk("R4 ar id", 64'(s_arid), 64'({MIDX, id}));
    step(); arvalid = 0;
    s_rvalid[s] = 1; s_rlast[s] = 1; s_rid[s*DIW +: DIW] = {MIDX, id};
    s_rdata[s*DW +: DW] = 64'hBEEF0000 + 64'(id); #1;
    chk("R5 rid strip", 64'({rvalid, rid}), 64'({1'b1, id}));
    step(); s_rvalid = 0; s_rlast = 0;
  endtask

  // entry: {is_read, slave, id}
  localparam logic [9:0] VEC [8] = '{
    {1'b0, 2'd0, 7'h05}, {1'b0, 2'd3, 7'h7F}, {1'b1, 2'd1, 7'h12}, {1'b0, 2'd2, 7'h00},
    {1'b1, 2'd3, 7'h40}, {1'b1, 2'd0, 7'h3A}, {1'b0, 2'd1, 7'h66}, {1'b1, 2'd2, 7'h01}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0; #1;
    // R11 reset state
    chk("R11 reset resp", 64'({bvalid, rvalid}), 64'(0));
    chk("R11 reset slave valids", 64'({s_awvalid, s_arvalid, s_wvalid}), 64'(0));
    // R6: data without a command is refused
    wvalid = 1; wlast = 1; #1;
    chk("R6 w no cmd", 64'({wready, s_wvalid}), 64'(0));
    wvalid = 0; wlast = 0;
    // R11: first command to slave 3 goes straight through
    awvalid = 1; awaddr = mk_addr(2'd3, '0); #1;
    chk("R11 any slave", 64'({awready, s_awvalid}), 64'({1'b1, 4'b1000}));
    awvalid = 0; #1;

    foreach (VEC[k]) begin
      if (VEC[k][9]) do_read(VEC[k][8:7], VEC[k][6:0]);
      else           do_write(VEC[k][8:7], VEC[k][6:0]);
    end

    // R3: write to slave 1 pending, read to slave 2 held
    awvalid = 1; awaddr = mk_addr(2'd1, '0); awid = 7'h11; step(); awvalid = 0;
    wvalid = 1; wlast = 1; step(); wvalid = 0; wlast = 0;
    arvalid = 1; araddr = mk_addr(2'd2, 29'h10); arid = 7'h22; #1;
    chk("R3 read held", 64'({arready, s_arvalid}), 64'(0));
    // R8: stray response from slave 0 is not seen
    s_bvalid[0] = 1; #1;
    chk("R8 stray b", 64'({bvalid, s_bready[0]}), 64'(0));
    s_bvalid = 4'b0010; s_bid[1*DIW +: DIW] = {MIDX, 7'h11}; #1;
    chk("R8 current b", 64'({bvalid, s_bready}), 64'({1'b1, 4'b0010}));
    step(); s_bvalid = 0; #1;
    chk("R3 read released", 64'({arready, s_arvalid}), 64'({1'b1, 4'b0100}));
    step(); arvalid = 0;
    // R9: non-final beat keeps blocking
    s_rvalid[2] = 1; s_rlast[2] = 0; s_rid[2*DIW +: DIW] = {MIDX, 7'h22}; step();
    awvalid = 1; awaddr = mk_addr(2'd0, '0); awid = 7'h33; #1;
    chk("R9 mid burst", 64'({awready, s_awvalid}), 64'(0));
    s_rlast[2] = 1; #1;
    chk("R9 last beat", 64'({rvalid, rlast, rid}), 64'({2'b11, 7'h22}));
    step(); s_rvalid = 0; s_rlast = 0; #1;
    chk("R9 released", 64'(s_awvalid), 64'(4'b0001));
    step(); awvalid = 0;
    wvalid = 1; wlast = 1; step(); wvalid = 0; wlast = 0;
    s_bvalid[0] = 1; s_bid[0 +: DIW] = {MIDX, 7'h33}; step(); s_bvalid = 0;
    // R10: simultaneous write (slave 3) and read (slave 0) while idle
    awvalid = 1; awaddr = mk_addr(2'd3, '0); awid = 7'h44;
    arvalid = 1; araddr = mk_addr(2'd0, '0); arid = 7'h55; #1;
    chk("R10 write first", 64'({s_awvalid, s_arvalid, arready}), 64'({4'b1000, 4'b0000, 1'b0}));
    step(); awvalid = 0; #1;
    chk("R10 read still held", 64'(s_arvalid), 64'(0));
    wvalid = 1; wlast = 1; step(); wvalid = 0; wlast = 0;
    s_bvalid[3] = 1; s_bid[3*DIW +: DIW] = {MIDX, 7'h44}; step(); s_bvalid = 0; #1;
    chk("R10 read after drain", 64'(s_arvalid), 64'(4'b0001));
    step(); arvalid = 0;
    s_rvalid[0] = 1; s_rlast[0] = 1; s_rid[0 +: DIW] = {MIDX, 7'h55}; #1;
    chk("R5 rid final", 64'(rid), 64'(7'h55));
    step(); s_rvalid = 0; s_rlast = 0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule